// File: doc/BRIEF.md
# Multiply-Accumulate Unit with Sectioned Preload

This block multiplies two 16-bit operands and folds the product into a 35-bit running result. The operands are read either as two's complement or as unsigned numbers, chosen by a sign-mode control. Per-operation controls pick one of three modes. The product can replace the result, be added to it, or have the result subtracted from it. A rounding control adds a half-unit at the top bit of the low section before accumulation. The arithmetic wraps modulo 2^35, with no saturation.

All state changes on one system clock. Three capture enables gate the updates: one for the X operand, one for the Y operand and one for the result. The sign-mode and operation controls are latched whenever either operand is captured. The result is exposed as three sections: a 3-bit extension, a 16-bit high part and a 16-bit low part. Each section has its own active-low output enable and a valid flag that mirrors that enable. The low section shares its port with the Y operand, so Y is captured only while that port is released.

When the preload control is set at a result capture, each released section is loaded from its port instead of from the computed value. A section whose port is driving keeps its value.

Top module: `mac_unit`

## Requirements
- R1: A synchronous active-high reset clears the operand registers, the latched controls and the whole 35-bit result, so all three output buses read zero.
- R2: The X register loads `x_in` when `x_en` is high. The Y register loads `y_in` only when `y_en` is high and `lo_oe_n` is high. Otherwise each holds its value.
- R3: The controls `sign_mode`, `acc_mode`, `sub_mode` and `rnd_mode` are latched as a group when `x_en` or `y_en` is high, and held otherwise.
- R4: With latched `sign_mode`=1 the operands are two's complement, and the product is sign-extended to 35 bits. With `sign_mode`=0 they are unsigned, and the product is zero-extended.
- R5: With latched `acc_mode`=0, a result capture stores the product, and the old result is discarded.
- R6: With latched `acc_mode`=1 and `sub_mode`=0, a result capture stores product plus result, modulo 2^35.
- R7: With latched `acc_mode`=1 and `sub_mode`=1, a result capture stores product minus result, modulo 2^35.
- R8: With latched `rnd_mode`=1, the value 2^15 is added to the product before the mode in R5 to R7 is applied.
- R9: The result changes only at a clock edge where `p_en` is high, and it uses the operand and control registers as they were before that edge.
- R10: When `p_en` and `preload` are both high, each section whose enable is high is loaded from its port. Bits 34:32 come from `ext_in`, bits 31:16 from `hi_in` and bits 15:0 from `y_in`.
- R11: During a preload, a section whose active-low enable is low keeps its previous value.
- R12: `ext_out`, `hi_out` and `lo_out` always show result bits 34:32, 31:16 and 15:0. Each valid flag is the inverse of its own enable, independent of the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| x_en | input | 1 | Capture enable for X and controls |
| y_en | input | 1 | Capture enable for Y and controls |
| p_en | input | 1 | Result capture enable |
| x_in | input | 16 | X operand |
| y_in | input | 16 | Y operand / low-section preload data |
| sign_mode | input | 1 | 1 = two's complement, 0 = unsigned |
| acc_mode | input | 1 | 1 = accumulate, 0 = load product |
| sub_mode | input | 1 | With acc_mode, 1 = product minus result |
| rnd_mode | input | 1 | Add 2^15 to the product |
| preload | input | 1 | Load released sections from ports at result capture |
| ext_oe_n | input | 1 | Active-low enable, extension section |
| hi_oe_n | input | 1 | Active-low enable, high section |
| lo_oe_n | input | 1 | Active-low enable, low section |
| ext_in | input | 3 | Extension preload data |
| hi_in | input | 16 | High-section preload data |
| ext_out | output | 3 | Result bits 34:32 |
| ext_vld | output | 1 | Extension port driving |
| hi_out | output | 16 | Result bits 31:16 |
| hi_vld | output | 1 | High port driving |
| lo_out | output | 16 | Result bits 15:0 |
| lo_vld | output | 1 | Low port driving |

## Verification
The bench builds the block with its default parameters: 16-bit operands and a 3-bit extension. This brings the real corner products within reach: the most negative operand squared, an all-ones unsigned square that fills 32 bits, and wrap past 2^35 after repeated accumulation. Random cycles mix the capture enables, the output enables and rare preloads. Preloads with some ports still driving therefore exercise the partial-section paths, against a wide-integer model.

// File: rtl/mac_pkg.sv
package mac_pkg;
    localparam int OP_W  = 16;
    localparam int EXT_W = 3;
    localparam int ACC_W = 2 * OP_W + EXT_W;

    typedef struct packed {
        logic sign_mode;
        logic acc_mode;
        logic sub_mode;
        logic rnd_mode;
    } mac_ctl_t;

    typedef enum logic [1:0] {
        OP_LOAD = 2'd0,
        OP_ADD  = 2'd1,
        OP_RSUB = 2'd2
    } mac_op_e;

    function automatic mac_op_e decode_op(mac_ctl_t c);
        if (!c.acc_mode)    return OP_LOAD;
        else if (c.sub_mode) return OP_RSUB;
        else                return OP_ADD;
    endfunction

    function automatic logic [ACC_W-1:0] widen(logic [OP_W-1:0] v, logic sgn);
        return {{(ACC_W-OP_W){sgn & v[OP_W-1]}}, v};
    endfunction
endpackage

// File: rtl/mac_opreg.sv
module mac_opreg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (en) q <= d;
    end

    AST_OPERAND_HOLD: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(q)); // R2
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
    import mac_pkg::*;
(
    input  logic [OP_W-1:0]  x_q,
    input  logic [OP_W-1:0]  y_q,
    input  mac_ctl_t         ctl,
    input  logic [ACC_W-1:0] acc_q,
    output logic [ACC_W-1:0] calc
);
    localparam logic [ACC_W-1:0] RND_ONE = ACC_W'(1) << (OP_W - 1);

    logic [ACC_W-1:0] xa, ya, prod, prod_r;
    mac_op_e          op;

    always_comb begin
        xa     = widen(x_q, ctl.sign_mode);
        ya     = widen(y_q, ctl.sign_mode);
        prod   = xa * ya;
        prod_r = prod + (ctl.rnd_mode ? RND_ONE : '0);
        op     = decode_op(ctl);
        unique case (op)
            OP_ADD:  calc = prod_r + acc_q;
            OP_RSUB: calc = prod_r - acc_q;
            default: calc = prod_r;
        endcase
    end
endmodule

// File: rtl/mac_accum.sv
module mac_accum
    import mac_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             p_en,
    input  logic             preload,
    input  logic             ext_oe_n,
    input  logic             hi_oe_n,
    input  logic             lo_oe_n,
    input  logic [EXT_W-1:0] ext_in,
    input  logic [OP_W-1:0]  hi_in,
    input  logic [OP_W-1:0]  lo_in,
    input  logic [ACC_W-1:0] calc,
    output logic [ACC_W-1:0] acc_q
);
    localparam int HI_LSB  = OP_W;
    localparam int EXT_LSB = 2 * OP_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (p_en) begin
            if (preload) begin
                if (ext_oe_n) acc_q[EXT_LSB +: EXT_W] <= ext_in;
                if (hi_oe_n)  acc_q[HI_LSB +: OP_W]   <= hi_in;
                if (lo_oe_n)  acc_q[0 +: OP_W]        <= lo_in;
            end else begin
                acc_q <= calc;
            end
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> acc_q == '0); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !p_en |=> $stable(acc_q)); // R9
    AST_PRELOAD_HI: assert property (@(posedge clk) disable iff (rst)
        (p_en && preload && hi_oe_n) |=> acc_q[HI_LSB +: OP_W] == $past(hi_in)); // R10
    AST_PRELOAD_EXT: assert property (@(posedge clk) disable iff (rst)
        (p_en && preload && ext_oe_n) |=> acc_q[EXT_LSB +: EXT_W] == $past(ext_in)); // R10
    AST_DRIVEN_LO_HOLD: assert property (@(posedge clk) disable iff (rst)
        (p_en && preload && !lo_oe_n) |=> $stable(acc_q[0 +: OP_W])); // R11
endmodule

// File: rtl/mac_unit.sv
module mac_unit
    import mac_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             x_en,
    input  logic             y_en,
    input  logic             p_en,
    input  logic [OP_W-1:0]  x_in,
    input  logic [OP_W-1:0]  y_in,
    input  logic             sign_mode,
    input  logic             acc_mode,
    input  logic             sub_mode,
    input  logic             rnd_mode,
    input  logic             preload,
    input  logic             ext_oe_n,
    input  logic             hi_oe_n,
    input  logic             lo_oe_n,
    input  logic [EXT_W-1:0] ext_in,
    input  logic [OP_W-1:0]  hi_in,
    output logic [EXT_W-1:0] ext_out,
    output logic             ext_vld,
    output logic [OP_W-1:0]  hi_out,
    output logic             hi_vld,
    output logic [OP_W-1:0]  lo_out,
    output logic             lo_vld
);
    logic [OP_W-1:0]  x_q, y_q;
    logic [ACC_W-1:0] acc_q, calc;
    mac_ctl_t         ctl_q;
    logic             y_cap, ctl_cap;

    assign y_cap   = y_en & lo_oe_n;
    assign ctl_cap = x_en | y_en;

    mac_opreg #(.W(OP_W)) u_xreg (
        .clk(clk), .rst(rst), .en(x_en), .d(x_in), .q(x_q)
    );
    mac_opreg #(.W(OP_W)) u_yreg (
        .clk(clk), .rst(rst), .en(y_cap), .d(y_in), .q(y_q)
    );

    always_ff @(posedge clk) begin
        if (rst)
            ctl_q <= '0;
        else if (ctl_cap)
            ctl_q <= '{sign_mode: sign_mode, acc_mode: acc_mode,
                       sub_mode: sub_mode, rnd_mode: rnd_mode};
    end

    AST_CTL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(x_en || y_en) |=> $stable(ctl_q)); // R3
    AST_Y_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (!lo_oe_n) |=> $stable(y_q)); // R2

    mac_datapath u_dp (
        .x_q(x_q), .y_q(y_q), .ctl(ctl_q), .acc_q(acc_q), .calc(calc)
    );

    mac_accum u_acc (
        .clk(clk), .rst(rst), .p_en(p_en), .preload(preload),
        .ext_oe_n(ext_oe_n), .hi_oe_n(hi_oe_n), .lo_oe_n(lo_oe_n),
        .ext_in(ext_in), .hi_in(hi_in), .lo_in(y_in),
        .calc(calc), .acc_q(acc_q)
    );

    assign ext_out = acc_q[2*OP_W +: EXT_W];
    assign hi_out  = acc_q[OP_W +: OP_W];
    assign lo_out  = acc_q[0 +: OP_W];
    assign ext_vld = ~ext_oe_n;
    assign hi_vld  = ~hi_oe_n;
    assign lo_vld  = ~lo_oe_n;
endmodule

// File: tb/test_mac_unit.sv
module test_mac_unit;
    logic        clk = 0;
    logic        rst = 1;
    logic        x_en = 0, y_en = 0, p_en = 0;
    logic [15:0] x_in = 0, y_in = 0, hi_in = 0;
    logic [2:0]  ext_in = 0;
    logic        sign_mode = 0, acc_mode = 0, sub_mode = 0, rnd_mode = 0, preload = 0;
    logic        ext_oe_n = 1, hi_oe_n = 1, lo_oe_n = 1;
    logic [2:0]  ext_out;
    logic [15:0] hi_out, lo_out;
    logic        ext_vld, hi_vld, lo_vld;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [15:0] mx = 0, my = 0;
    logic        mtc = 0, macm = 0, msub = 0, mrnd = 0;
    logic [34:0] macc = 0;

    mac_unit i_mac_unit (
        .clk(clk), .rst(rst), .x_en(x_en), .y_en(y_en), .p_en(p_en),
        .x_in(x_in), .y_in(y_in), .sign_mode(sign_mode), .acc_mode(acc_mode),
        .sub_mode(sub_mode), .rnd_mode(rnd_mode), .preload(preload),
        .ext_oe_n(ext_oe_n), .hi_oe_n(hi_oe_n), .lo_oe_n(lo_oe_n),
        .ext_in(ext_in), .hi_in(hi_in), .ext_out(ext_out), .ext_vld(ext_vld),
        .hi_out(hi_out), .hi_vld(hi_vld), .lo_out(lo_out), .lo_vld(lo_vld)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000) begin
            errors++;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [34:0] f_prod(logic [15:0] a, logic [15:0] b, logic tc, logic rnd);
        longint pa, pb, p;
        pa = tc ? longint'($signed(a)) : longint'(a);
        pb = tc ? longint'($signed(b)) : longint'(b);
        p  = pa * pb + (rnd ? 64'sd32768 : 64'sd0);
        return p[34:0];
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Advance one edge with the current inputs, update the model, compare outputs.
    task automatic tick(string tag);
        logic [15:0] nx, ny;
        logic        ntc, nacm, nsub, nrnd;
        logic [34:0] nacc, p;
        nx = mx; ny = my; ntc = mtc; nacm = macm; nsub = msub; nrnd = mrnd; nacc = macc;
        if (rst) begin
            nx = 0; ny = 0; ntc = 0; nacm = 0; nsub = 0; nrnd = 0; nacc = 0;
        end else begin
            if (x_en) nx = x_in;
            if (y_en && lo_oe_n) ny = y_in;
            if (x_en || y_en) begin
                ntc = sign_mode; nacm = acc_mode; nsub = sub_mode; nrnd = rnd_mode;
            end
            if (p_en) begin
                if (preload) begin
                    if (ext_oe_n) nacc[34:32] = ext_in;
                    if (hi_oe_n)  nacc[31:16] = hi_in;
                    if (lo_oe_n)  nacc[15:0]  = y_in;
                end else begin
                    p = f_prod(mx, my, mtc, mrnd);
                    if (!macm)     nacc = p;
                    else if (msub) nacc = p - macc;
                    else           nacc = p + macc;
                end
            end
        end
        @(posedge clk);
        #1;
        mx = nx; my = ny; mtc = ntc; macm = nacm; msub = nsub; mrnd = nrnd; macc = nacc;
        check(tag, {29'd0, ext_out, hi_out, lo_out}, {29'd0, macc});
        check("R12 valid flags", {61'd0, ext_vld, hi_vld, lo_vld},
              {61'd0, ~ext_oe_n, ~hi_oe_n, ~lo_oe_n});
    endtask

    task automatic idle();
        x_en = 0; y_en = 0; p_en = 0; preload = 0;
    endtask

    // Capture operands and controls, then capture the result on the next edge.
    task automatic mac_op(string tag, logic [15:0] a, logic [15:0] b,
                          logic tc, logic am, logic sm, logic rm, logic [34:0] expv);
        lo_oe_n = 1; ext_oe_n = 1; hi_oe_n = 1;
        x_in = a; y_in = b; sign_mode = tc; acc_mode = am; sub_mode = sm; rnd_mode = rm;
        x_en = 1; y_en = 1; p_en = 0; preload = 0;
        tick(tag);
        x_en = 0; y_en = 0; p_en = 1;
        tick(tag);
        check(tag, {29'd0, ext_out, hi_out, lo_out}, {29'd0, expv});
        idle();
    endtask

    initial begin
        void'($urandom(32'd2024));
        rst = 1;
        tick("R1 reset");
        tick("R1 reset");
        check("R1 reset result zero", {29'd0, ext_out, hi_out, lo_out}, 64'd0);
        rst = 0;

        // R5 / R4 signed and unsigned corners
        mac_op("R4 signed -1*-1", 16'hFFFF, 16'hFFFF, 1, 0, 0, 0, 35'd1);
        mac_op("R4 unsigned max square", 16'hFFFF, 16'hFFFF, 0, 0, 0, 0, 35'h0FFFE0001);
        mac_op("R4 signed min square", 16'h8000, 16'h8000, 1, 0, 0, 0, 35'h040000000);
        mac_op("R5 signed -1*1 load", 16'hFFFF, 16'h0001, 1, 0, 0, 0, 35'h7FFFFFFFF);
        // R6 add wraps past 2^35: -1 + 3*5
        mac_op("R6 add wrap", 16'd3, 16'd5, 1, 1, 0, 0, 35'd14);
        // R7 product minus result: 2*2 - 14
        mac_op("R7 reverse subtract", 16'd2, 16'd2, 0, 1, 1, 0, 35'h7FFFFFFF6);
        // R8 rounding on a load
        mac_op("R8 round", 16'd1, 16'd1, 0, 0, 0, 1, 35'h000008001);

        // R9 no change without p_en, even with new operands
        x_in = 16'd77; y_in = 16'd9; x_en = 1; y_en = 1; p_en = 0;
        tick("R9 hold without p_en");
        check("R9 hold without p_en", {29'd0, ext_out, hi_out, lo_out}, {29'd0, 35'h000008001});
        idle();

        // R2 Y blocked while low port drives: product uses old Y (9)
        lo_oe_n = 0; y_in = 16'd100; y_en = 1; x_en = 0;
        sign_mode = 0; acc_mode = 0; sub_mode = 0; rnd_mode = 0;
        tick("R2 y blocked");
        idle(); lo_oe_n = 1; p_en = 1;
        tick("R2 y blocked");
        check("R2 y blocked product", {29'd0, ext_out, hi_out, lo_out}, {29'd0, 35'd693});
        idle();

        // R10 full preload
        ext_in = 3'b101; hi_in = 16'hBEEF; y_in = 16'h1234;
        ext_oe_n = 1; hi_oe_n = 1; lo_oe_n = 1; p_en = 1; preload = 1;
        tick("R10 full preload");
        check("R10 full preload", {29'd0, ext_out, hi_out, lo_out}, {29'd0, 3'b101, 16'hBEEF, 16'h1234});
        // R11 partial preload: hi and lo driving, only ext loads
        ext_in = 3'b010; hi_in = 16'h0000; y_in = 16'hFFFF; hi_oe_n = 0; lo_oe_n = 0;
        tick("R11 partial preload");
        check("R11 partial preload", {29'd0, ext_out, hi_out, lo_out}, {29'd0, 3'b010, 16'hBEEF, 16'h1234});
        idle(); hi_oe_n = 1; lo_oe_n = 1;

        // R3 controls held when no operand capture: old mode is load
        sign_mode = 1; acc_mode = 1; sub_mode = 1; rnd_mode = 1; p_en = 1;
        tick("R3 controls held");
        check("R3 controls held", {29'd0, ext_out, hi_out, lo_out}, {29'd0, 35'd693});
        idle();

        // Random mix covering R2 through R12
        for (int i = 0; i < 4000; i++) begin
            x_en = ($urandom % 2) == 0;
            y_en = ($urandom % 2) == 0;
            p_en = ($urandom % 3) == 0;
            preload = ($urandom % 8) == 0;
            x_in = 16'($urandom); y_in = 16'($urandom); hi_in = 16'($urandom);
            ext_in = 3'($urandom);
            sign_mode = 1'($urandom); acc_mode = ($urandom % 4) != 0;
            sub_mode = 1'($urandom); rnd_mode = ($urandom % 4) == 0;
            ext_oe_n = ($urandom % 4) != 0; hi_oe_n = ($urandom % 4) != 0;
            lo_oe_n = ($urandom % 4) != 0;
            rst = ($urandom % 500) == 0;
            tick(rst ? "R1 random reset" : "R9 random accumulate");
        end
        rst = 0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule